// File: doc/BRIEF.md
# Delta-Sigma Converter Frame Reader

This block sits on the host side of a three-wire serial link to a delta-sigma converter. It fetches one 32-bit result frame per request. When `start` is pulsed, the block pulls chip select low with the serial clock parked low. It then watches the data line, whose first frame bit is a live end-of-conversion flag. The flag is high while the converter is still working. Only when the flag reads low does the block generate the serial clock and collect the frame, most significant bit first, one bit per rising edge. If the flag never drops within a programmable number of system cycles, the block gives up and reports a timeout.

Once the frame is in, the block releases chip select and pulses `done` for one cycle. The frame is decoded into four outputs: a channel indicator, a 25-bit two's-complement result, five sub-LSB bits, and overrange/underrange flags taken from the sign/MSB pair. The outputs hold their values until the next completed frame. The serial clock is the system clock divided down by a parameter. Serial data passes through a synchronizer before any use.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is asserted and directly after it, `cs_n` is 1, `sclk` is 0, and `done`, `busy`, `timeout_err` and all data outputs are 0.
- R2: A `start` seen while idle raises `busy` and drives `cs_n` low from the next cycle on. `sclk` stays 0 while polling, and `sclk` is never high while `cs_n` is high.
- R3: No rising edge appears on `sclk` while `sdi` still shows the end-of-conversion flag high (1 = conversion in progress).
- R4: Each frame gets exactly 32 rising `sclk` edges, spaced 2*CLK_DIV system cycles apart.
- R5: The frame is taken MSB first, frame bit 31 first. `chan` equals frame bit 30 (0 = channel 0, 1 = channel 1).
- R6: `result` is the 25-bit two's-complement value {~bit29, bit28..bit5}. Bit 29 is the sign bit, 1 meaning positive.
- R7: `sub_lsb` equals frame bits 4..0.
- R8: `over_range` = bit29 AND bit28. `under_range` = NOT bit29 AND NOT bit28. The two flags are never both set.
- R9: After the 32nd edge, `cs_n` returns to 1, `done` is high for exactly one cycle with `busy` low, and the data outputs change only in a `done` cycle.
- R10: If the flag stays high for POLL_LIMIT cycles of polling, `done` pulses with `timeout_err` = 1 at POLL_LIMIT cycles after the accepted `start`. No `sclk` edge is issued and the data outputs keep their previous values.
- R11: A `start` pulse while `busy` is high has no effect. The frame in flight completes normally and no further frame follows.
- R12: `timeout_err` clears when the next `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request one frame (accepted when idle) |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select to converter, active low |
| sclk | output | 1 | Serial clock to converter |
| busy | output | 1 | A request is being served |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Last request ended without a ready flag |
| chan | output | 1 | Channel indicator of last frame |
| result | output | 25 | Signed conversion result of last frame |
| sub_lsb | output | 5 | Sub-LSB bits of last frame |
| over_range | output | 1 | Input above positive full scale |
| under_range | output | 1 | Input below negative full scale |

## Verification
The bench varies the converter's ready delay from zero to just under the timeout. This catches a reader that clocks before the flag drops (it collects a shifted frame) and one that misses the settling time of its synchronizer (it starts on a stale low). The frames cover both out-of-range codes, the all-ones negative code, zero, and both channels, so an inverted sign or a field off by one bit changes the decoded values. A stuck converter exposes a timeout that fires a cycle early or late, or that disturbs the held result. A second `start` mid-frame exposes a reader that restarts or issues an extra frame.

// File: rtl/adcfr_pkg.sv
package adcfr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_POLL   = 2'd1,
      ST_CLOCK  = 2'd2,
      ST_FINISH = 2'd3
   } rdr_state_t;
endpackage

// File: rtl/adcfr_sync.sv
module adcfr_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES >= 2) begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end else begin : g_single
         logic flop;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flop <= RST_VAL;
            else        flop <= d;
         end
         assign q = flop;
      end
   endgenerate
endmodule

// File: rtl/adcfr_sclk_gen.sv
module adcfr_sclk_gen #(
   parameter int HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic sample
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CW-1:0] cnt;
   logic          sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         sclk_q <= 1'b0;
      end else if (!run) begin
         cnt    <= '0;
         sclk_q <= 1'b0;
      end else if (cnt == CW'(HALF - 1)) begin
         cnt    <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         cnt    <= cnt + CW'(1);
      end
   end

   // last cycle of the high phase: data has been stable since the previous fall
   assign sample = run && sclk_q && (cnt == CW'(HALF - 1));
   assign sclk   = sclk_q;
endmodule

// File: rtl/adcfr_shifter.sv
module adcfr_shifter #(
   parameter int BITS = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            shift_en,
   input  logic            din,
   output logic [BITS-2:0] frame,
   output logic            last
);
   localparam int CW = $clog2(BITS);

   logic [CW-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame <= '0;
         idx   <= '0;
      end else if (clear) begin
         frame <= '0;
         idx   <= '0;
      end else if (shift_en) begin
         frame <= {frame[BITS-3:0], din};
         idx   <= idx + CW'(1);
      end
   end

   assign last = shift_en && (idx == CW'(BITS - 1));
endmodule

// File: rtl/adcfr_decode.sv
module adcfr_decode #(
   parameter int BITS     = 32,
   parameter int RESULT_W = 24,
   parameter int SUB_W    = 5
) (
   input  logic [BITS-2:0]   frame,
   output logic              chan,
   output logic [RESULT_W:0] result,
   output logic [SUB_W-1:0]  sub_lsb,
   output logic              over_range,
   output logic              under_range
);
   localparam int CH_POS   = BITS - 2;
   localparam int SIGN_POS = BITS - 3;
   localparam int MSB_POS  = BITS - 4;

   assign chan        = frame[CH_POS];
   assign result      = {~frame[SIGN_POS], frame[MSB_POS:SUB_W]};
   assign sub_lsb     = frame[SUB_W-1:0];
   assign over_range  =  frame[SIGN_POS] &  frame[MSB_POS];
   assign under_range = ~frame[SIGN_POS] & ~frame[MSB_POS];
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
   import adcfr_pkg::*;
#(
   parameter int CLK_DIV     = 4,
   parameter int SYNC_STAGES = 2,
   parameter int POLL_LIMIT  = 4096,
   parameter int FRAME_BITS  = 32,
   parameter int RESULT_W    = 24,
   parameter int SUB_W       = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              sdi,
   output logic              cs_n,
   output logic              sclk,
   output logic              busy,
   output logic              done,
   output logic              timeout_err,
   output logic              chan,
   output logic [RESULT_W:0] result,
   output logic [SUB_W-1:0]  sub_lsb,
   output logic              over_range,
   output logic              under_range
);
   localparam int SETTLE = SYNC_STAGES + 1;
   localparam int WAIT_W = $clog2(POLL_LIMIT + 1);

   generate
      if (CLK_DIV < SETTLE) begin : g_bad_div
         $error("CLK_DIV must cover the synchronizer latency");
      end
      if (FRAME_BITS != RESULT_W + SUB_W + 3) begin : g_bad_frame
         $error("frame width does not match result and sub-LSB widths");
      end
      if (POLL_LIMIT <= SETTLE) begin : g_bad_poll
         $error("POLL_LIMIT must exceed synchronizer settle time");
      end
   endgenerate

   rdr_state_t        state;
   logic [WAIT_W-1:0] wait_cnt;
   logic              sdi_s;
   logic              sample;
   logic              last;
   logic [FRAME_BITS-2:0] frame;
   logic              d_chan, d_over, d_under;
   logic [RESULT_W:0] d_result;
   logic [SUB_W-1:0]  d_sub;

   adcfr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s)
   );

   adcfr_sclk_gen #(.HALF(CLK_DIV)) sclk_i (
      .clk(clk), .rst_n(rst_n), .run(state == ST_CLOCK),
      .sclk(sclk), .sample(sample)
   );

   adcfr_shifter #(.BITS(FRAME_BITS)) shift_i (
      .clk(clk), .rst_n(rst_n),
      .clear(state == ST_IDLE && start),
      .shift_en(sample), .din(sdi_s),
      .frame(frame), .last(last)
   );

   adcfr_decode #(.BITS(FRAME_BITS), .RESULT_W(RESULT_W), .SUB_W(SUB_W)) dec_i (
      .frame(frame), .chan(d_chan), .result(d_result), .sub_lsb(d_sub),
      .over_range(d_over), .under_range(d_under)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         wait_cnt    <= '0;
         cs_n        <= 1'b1;
         done        <= 1'b0;
         timeout_err <= 1'b0;
         chan        <= 1'b0;
         result      <= '0;
         sub_lsb     <= '0;
         over_range  <= 1'b0;
         under_range <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state       <= ST_POLL;
                  cs_n        <= 1'b0;
                  wait_cnt    <= '0;
                  timeout_err <= 1'b0;
               end
            end
            ST_POLL: begin
               wait_cnt <= wait_cnt + WAIT_W'(1);
               if (wait_cnt >= WAIT_W'(SETTLE) && !sdi_s) begin
                  state <= ST_CLOCK;
               end else if (wait_cnt == WAIT_W'(POLL_LIMIT - 1)) begin
                  state       <= ST_IDLE;
                  cs_n        <= 1'b1;
                  done        <= 1'b1;
                  timeout_err <= 1'b1;
               end
            end
            ST_CLOCK: begin
               if (last) state <= ST_FINISH;
            end
            ST_FINISH: begin
               state       <= ST_IDLE;
               cs_n        <= 1'b1;
               done        <= 1'b1;
               chan        <= d_chan;
               result      <= d_result;
               sub_lsb     <= d_sub;
               over_range  <= d_over;
               under_range <= d_under;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);
endmodule

// File: rtl/adcfr_checker.sv
module adcfr_checker #(
   parameter int RESULT_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              sclk,
   input logic              busy,
   input logic              done,
   input logic              timeout_err,
   input logic [RESULT_W:0] result,
   input logic              over_range,
   input logic              under_range
);
   assert_sclk_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   assert_edge_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> (busy && !cs_n));

   assert_range_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(over_range && under_range));

   assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n);

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);

   assert_timeout_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_err) |-> done);
endmodule

bind adc_frame_reader adcfr_checker #(.RESULT_W(RESULT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .busy(busy),
   .done(done), .timeout_err(timeout_err), .result(result),
   .over_range(over_range), .under_range(under_range)
);

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_DIV    = 4;
   localparam int SYNC       = 2;
   localparam int POLL_LIMIT = 400;
   localparam int NVEC       = 6;

   localparam logic [31:0] VEC_FRAME [NVEC] = '{
      32'h3000_001F, 32'h4F00_0000, 32'h2ABC_DE15,
      32'h5555_5555, 32'h2000_0000, 32'h1FFF_FFFF };
   localparam int VEC_DELAY [NVEC] = '{0, 5, 40, 100, 3, 250};
   localparam bit VEC_POKE  [NVEC] = '{0, 0, 1, 0, 0, 0};

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sdi = 1'b1;
   logic cs_n, sclk, busy, done, timeout_err, chan, over_range, under_range;
   logic [24:0] result;
   logic [4:0]  sub_lsb;

   int total = 0, bad = 0;
   bit finished = 0;

   logic [31:0] dev_frame = '0;
   int  conv_left = 0, idx = 31, rises = 0, since_rise = 0;
   int  per_min = 0, per_max = 0, done_cnt = 0;
   bit  early = 0;
   logic prev_sclk = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_frame_reader #(.CLK_DIV(CLK_DIV), .SYNC_STAGES(SYNC), .POLL_LIMIT(POLL_LIMIT)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .sdi(sdi), .cs_n(cs_n), .sclk(sclk),
      .busy(busy), .done(done), .timeout_err(timeout_err), .chan(chan),
      .result(result), .sub_lsb(sub_lsb), .over_range(over_range),
      .under_range(under_range));

   // converter model: output changes on falling serial clock edges
   initial forever begin
      @(negedge clk);
      if (done) done_cnt++;
      if (sclk && !prev_sclk) begin
         rises++;
         if (conv_left > 0) early = 1;
         if (rises > 1) begin
            if (since_rise < per_min) per_min = since_rise;
            if (since_rise > per_max) per_max = since_rise;
         end
         since_rise = 0;
      end
      since_rise++;
      if (cs_n) begin
         idx = 31;
         sdi = 1'b1;
      end else if (conv_left > 0) begin
         conv_left--;
         sdi = 1'b1;
      end else begin
         if (prev_sclk && !sclk) idx--;
         sdi = (idx >= 0) ? dev_frame[idx] : 1'b1;
      end
      prev_sclk = sclk;
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_done(output int n);
      n = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic run_frame(logic [31:0] f, int delay, bit poke);
      int n, d0;
      logic [24:0] exp_res;
      dev_frame = f; conv_left = delay; rises = 0; early = 0;
      per_min = 1000000; per_max = 0; d0 = done_cnt;
      pulse_start();
      chk("R2 cs_n low after start", {31'd0, cs_n}, 32'd0);
      chk("R2 sclk parked while polling", {31'd0, sclk}, 32'd0);
      chk("R2 busy", {31'd0, busy}, 32'd1);
      if (poke) begin
         repeat (100) @(negedge clk);
         start = 1'b1; @(negedge clk); start = 1'b0;   // R11: must be ignored
      end
      wait_done(n);
      exp_res = {~f[29], f[28:5]};
      chk("R9 done seen", {31'd0, done}, 32'd1);
      chk("R9 busy low at done", {31'd0, busy}, 32'd0);
      chk("R9 cs_n released", {31'd0, cs_n}, 32'd1);
      chk("R3 no edge before ready", {31'd0, early}, 32'd0);
      chk("R4 edge count", rises, 32);
      chk("R4 period min", per_min, 2*CLK_DIV);
      chk("R4 period max", per_max, 2*CLK_DIV);
      chk("R5 chan", {31'd0, chan}, {31'd0, f[30]});
      chk("R6 result", {7'd0, result}, {7'd0, exp_res});
      chk("R7 sub_lsb", {27'd0, sub_lsb}, {27'd0, f[4:0]});
      chk("R8 over", {31'd0, over_range}, {31'd0, f[29] & f[28]});
      chk("R8 under", {31'd0, under_range}, {31'd0, ~f[29] & ~f[28]});
      chk("R10 no timeout", {31'd0, timeout_err}, 32'd0);
      @(negedge clk);
      chk("R9 done one cycle", {31'd0, done}, 32'd0);
      repeat (30) @(negedge clk);
      chk("R9 result held", {7'd0, result}, {7'd0, exp_res});
      chk("R11 single completion", done_cnt - d0, 1);
      chk("R11 stays idle", {30'd0, busy, cs_n}, 32'd1);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
   end

   initial begin
      int n;
      logic [24:0] held;
      repeat (3) @(negedge clk);
      chk("R1 cs_n in reset", {31'd0, cs_n}, 32'd1);
      chk("R1 sclk in reset", {31'd0, sclk}, 32'd0);
      chk("R1 flags in reset", {28'd0, done, busy, timeout_err, chan}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 result after reset", {7'd0, result}, 32'd0);
      chk("R1 range flags after reset", {30'd0, over_range, under_range}, 32'd0);

      for (int i = 0; i < NVEC; i++) run_frame(VEC_FRAME[i], VEC_DELAY[i], VEC_POKE[i]);

      // R10: converter never becomes ready
      held = result; rises = 0; conv_left = 1000000;
      pulse_start();
      wait_done(n);
      chk("R10 timeout latency", n, POLL_LIMIT);
      chk("R10 timeout flag", {31'd0, timeout_err}, 32'd1);
      chk("R10 no clock edges", rises, 0);
      chk("R10 result untouched", {7'd0, result}, {7'd0, held});
      chk("R10 cs_n released", {31'd0, cs_n}, 32'd1);
      @(negedge clk);
      conv_left = 0;
      repeat (5) @(negedge clk);

      // R12: next request clears the error
      dev_frame = 32'h6123_4567;
      pulse_start();
      chk("R12 timeout cleared on start", {31'd0, timeout_err}, 32'd0);
      wait_done(n);
      chk("R12 frame after timeout", {7'd0, result}, {7'd0, ~dev_frame[29], dev_frame[28:5]});
      chk("R12 chan after timeout", {31'd0, chan}, 32'd1);

      repeat (5) @(negedge clk);
      report();
   end
endmodule